// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block configures a downstream programmable device through its one-bit serial configuration port. It acts as the master of the exchange. It pulls the device's program input low, watches the open-drain initialisation line fall and then rise again, and streams the bitstream out one bit per configuration clock, most significant bit first. When the last bit has gone out, it keeps the data line high and keeps clocking until the device raises its done line.

Software or a boot sequencer gives a start pulse together with the number of bitstream bytes. The bytes then arrive on a plain valid/ready stream. Before each byte the loader checks the initialisation line. If that line is low while done is still low, the device has flagged a checksum fault and the load stops. Every wait phase is bounded by a cycle-count timeout. The result is reported with a one-cycle finish pulse, a pass flag and a two-bit cause code. A separate abort pulse marks the failures in which the device was left part-way through configuration.

Top module: `sercfg_loader`

## Requirements
- R1: A start pulse that arrives while idle drives `prog_n_o` low in the next cycle. It also latches `nbytes_i`. A start pulse that arrives while a load is running has no effect.
- R2: With program asserted, the loader waits for `init_n_i`=0 for at most TIMEOUT_CYC cycles. It then keeps program low for HOLD_CYC further cycles and releases it. After that it waits for `init_n_i`=1 for at most TIMEOUT_CYC cycles before it sends any data.
- R3: Each byte goes out MSB first as 8 bits. For each bit, `cclk_o` falls and the new bit appears on `dout_o` in the same cycle. The clock stays low for HALF_CYC cycles, then stays high for HALF_CYC cycles, and `dout_o` does not change while the clock is high.
- R4: Before each byte, if `init_n_i`=0 while `done_i`=0, the load ends with cause code 1 (checksum fault), an abort pulse, and no further byte accepted.
- R5: `in_ready_o` is high only between bytes, with bytes still owed and no checksum fault present. A new byte is therefore accepted only after the high phase of the previous byte's eighth bit has finished.
- R6: Once all bytes have been sent, or straight away for a byte count of 0, `dout_o` is held at 1. `cclk_o` then toggles every HALF_CYC cycles until `done_i`=1, which ends the load with a pass.
- R7: Completion produces a one-cycle `fin_o` pulse. `pass_o` and `err_o` hold their values until the next accepted start. The cause codes are 0 pass, 1 checksum fault, 2 initialisation timeout and 3 done timeout, and `pass_o` is 1 exactly when the code is 0.
- R8: `abort_o` pulses for one cycle, in the same cycle as `fin_o`, on both initialisation timeouts and on a checksum fault. It does not pulse on a done timeout.
- R9: If `done_i` stays low for TIMEOUT_CYC cycles of trailing clocks, the load ends with cause code 3. On every finish, `prog_n_o` is released, and `cclk_o` and `dout_o` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (sampled only while idle) |
| nbytes_i | input | CNT_W | Number of bitstream bytes for this load |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Loader accepts the stream byte this cycle |
| prog_n_o | output | 1 | Device program request, active low |
| cclk_o | output | 1 | Configuration clock to the device |
| dout_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Device initialisation / error line, active low |
| done_i | input | 1 | Device configuration-complete line |
| abort_o | output | 1 | One-cycle pulse when the device was left mid-configuration |
| fin_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last load |
| err_o | output | 2 | Cause code of the last load |

## Verification
The properties assume that `init_n_i` and `done_i` are already synchronous to `clk` and change only at clock edges. They also assume that the stream holds a byte stable while `in_valid_i` is high. The bench's device stand-in moves both lines only from its clocked process, using counters it keeps of program-low cycles, program-release cycles and rising configuration clocks. The feeder changes its byte only after a handshake. Runs with a device that never answers, with one that reports a checksum fault in the middle of a load, and with one that never raises done all stay inside these assumptions, because each of them only holds a line constant.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_HOLD,
    S_WAITHI,
    S_NEXT,
    S_SHIFT,
    S_TAIL
  } cfg_st_e;

  typedef enum logic [1:0] {
    E_OK      = 2'd0,
    E_CRC     = 2'd1,
    E_INIT_TO = 2'd2,
    E_DONE_TO = 2'd3
  } cfg_err_e;

  // True in the cycle that completes a window of lim cycles counted from 0.
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sercfg_count.sv
module sercfg_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/sercfg_shreg.sv
module sercfg_shreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] val_i,
  input  logic          shift_i,
  output logic          bit_o,
  output logic          last_o
);

  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sr_q;
  logic [IW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= val_i;
      left_q <= IW'(DW - 1);
    end else if (shift_i) begin
      sr_q   <= {sr_q[DW-2:0], 1'b1};
      left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sr_q[DW-1];
  assign last_o = (left_q == '0);

endmodule

// File: rtl/sercfg_loader.sv
module sercfg_loader
  import sercfg_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2,
  parameter int unsigned TIMEOUT_CYC = 1_000_000,
  parameter int unsigned HOLD_CYC    = 100,
  parameter int unsigned CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             dout_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             abort_o,
  output logic             fin_o,
  output logic             pass_o,
  output logic [1:0]       err_o
);

  localparam int unsigned WT_MAX = max2(TIMEOUT_CYC, HOLD_CYC);
  localparam int unsigned WT_W   = $clog2(WT_MAX + 1);
  localparam int unsigned PH_W   = $clog2(HALF_CYC + 1);

  cfg_st_e          st, st_nx;
  logic             prog_q, cclk_q, fin_q, abort_q, pass_q;
  cfg_err_e         err_q, fin_code;
  logic [CNT_W-1:0] left_q;
  logic [WT_W-1:0]  wt_cnt;
  logic [PH_W-1:0]  ph_cnt;
  logic             st_chg, ph_clr, to_hit, hold_hit, ph_tick;
  logic             sr_bit, sr_last, sr_load, sr_shift;
  logic [7:0]       sr_val;
  logic             crc_seen, owed;

  // Named events, shared by the datapath and the bound checker
  logic ev_start, ev_init_seen, ev_rst_to, ev_hold_end, ev_init_clr, ev_hi_to;
  logic ev_crc, ev_take, ev_empty, ev_rise, ev_fall, ev_byte_end;
  logic ev_done_ok, ev_done_to, ev_tail_tog, ev_finish, in_tail;

  assign to_hit   = at_limit(32'(wt_cnt), TIMEOUT_CYC);
  assign hold_hit = at_limit(32'(wt_cnt), HOLD_CYC);
  assign ph_tick  = at_limit(32'(ph_cnt), HALF_CYC);

  assign crc_seen = !done_i && !init_n_i;
  assign owed     = (left_q != '0);
  assign in_tail  = (st == S_TAIL);

  assign ev_start     = (st == S_IDLE) && start_i;
  assign ev_init_seen = (st == S_RST) && !init_n_i;
  assign ev_rst_to    = (st == S_RST) && init_n_i && to_hit;
  assign ev_hold_end  = (st == S_HOLD) && hold_hit;
  assign ev_init_clr  = (st == S_WAITHI) && init_n_i;
  assign ev_hi_to     = (st == S_WAITHI) && !init_n_i && to_hit;
  assign ev_crc       = (st == S_NEXT) && owed && crc_seen;
  assign in_ready_o   = (st == S_NEXT) && owed && !crc_seen;
  assign ev_take      = in_ready_o && in_valid_i;
  assign ev_empty     = (st == S_NEXT) && !owed;
  assign ev_rise      = (st == S_SHIFT) && ph_tick && !cclk_q;
  assign ev_fall      = (st == S_SHIFT) && ph_tick && cclk_q && !sr_last;
  assign ev_byte_end  = (st == S_SHIFT) && ph_tick && cclk_q && sr_last;
  assign ev_done_ok   = in_tail && done_i;
  assign ev_done_to   = in_tail && !done_i && to_hit;
  assign ev_tail_tog  = in_tail && !done_i && !to_hit && ph_tick;
  assign ev_finish    = ev_rst_to || ev_hi_to || ev_crc || ev_done_ok || ev_done_to;

  always_comb begin
    if (ev_crc)                      fin_code = E_CRC;
    else if (ev_rst_to || ev_hi_to)  fin_code = E_INIT_TO;
    else if (ev_done_to)             fin_code = E_DONE_TO;
    else                             fin_code = E_OK;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:   if (ev_start)     st_nx = S_RST;
      S_RST:    if (ev_init_seen) st_nx = S_HOLD;
      S_HOLD:   if (ev_hold_end)  st_nx = S_WAITHI;
      S_WAITHI: if (ev_init_clr)  st_nx = S_NEXT;
      S_NEXT: begin
        if (ev_empty)     st_nx = S_TAIL;
        else if (ev_take) st_nx = S_SHIFT;
      end
      S_SHIFT:  if (ev_byte_end)  st_nx = S_NEXT;
      default: ;
    endcase
    if (ev_finish) st_nx = S_IDLE;
  end

  assign st_chg = (st_nx != st);
  assign ph_clr = ph_tick || st_chg;

  sercfg_count #(.W(WT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr_i(st_chg), .cnt_o(wt_cnt)
  );

  sercfg_count #(.W(PH_W)) u_half (
    .clk(clk), .rst_n(rst_n), .clr_i(ph_clr), .cnt_o(ph_cnt)
  );

  assign sr_load  = ev_take || ev_empty || ev_finish;
  assign sr_val   = ev_take ? in_data_i : (ev_empty ? 8'hFF : 8'h00);
  assign sr_shift = ev_fall;

  sercfg_shreg #(.DW(8)) u_sr (
    .clk(clk), .rst_n(rst_n), .load_i(sr_load), .val_i(sr_val),
    .shift_i(sr_shift), .bit_o(sr_bit), .last_o(sr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      prog_q  <= 1'b0;
      cclk_q  <= 1'b0;
      left_q  <= '0;
      fin_q   <= 1'b0;
      abort_q <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= E_OK;
    end else begin
      st      <= st_nx;
      fin_q   <= ev_finish;
      abort_q <= ev_rst_to || ev_hi_to || ev_crc;
      if (ev_start) begin
        prog_q <= 1'b1;
        left_q <= nbytes_i;
        pass_q <= 1'b0;
        err_q  <= E_OK;
      end
      if (ev_hold_end) prog_q <= 1'b0;
      if (ev_take) begin
        left_q <= left_q - 1'b1;
        cclk_q <= 1'b0;
      end
      if (ev_rise)     cclk_q <= 1'b1;
      if (ev_fall)     cclk_q <= 1'b0;
      if (ev_tail_tog) cclk_q <= ~cclk_q;
      if (ev_finish) begin
        prog_q <= 1'b0;
        cclk_q <= 1'b0;
        pass_q <= ev_done_ok;
        err_q  <= fin_code;
      end
    end
  end

  assign prog_n_o = ~prog_q;
  assign cclk_o   = cclk_q;
  assign dout_o   = sr_bit;
  assign fin_o    = fin_q;
  assign abort_o  = abort_q;
  assign pass_o   = pass_q;
  assign err_o    = err_q;

endmodule

// File: rtl/sercfg_loader_chk.sv
module sercfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_take,
  input logic       ev_crc,
  input logic       in_tail,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       dout_o,
  input logic       in_ready_o,
  input logic       fin_o,
  input logic       pass_o,
  input logic [1:0] err_o,
  input logic       abort_o
);

  a_r1_prog_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !prog_n_o);

  a_r3_data_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(dout_o));

  a_r5_no_take_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |=> !in_ready_o);

  a_r4_crc_reported: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |=> (abort_o && fin_o && err_o == 2'd1));

  a_r6_tail_data_high: assert property (@(posedge clk) disable iff (!rst_n)
    in_tail |-> dout_o);

  a_r7_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);

  a_r7_pass_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (pass_o == (err_o == 2'd0)));

  a_r8_abort_is_fail: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (fin_o && !pass_o && err_o != 2'd3));

endmodule

bind sercfg_loader sercfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_take(ev_take),
  .ev_crc(ev_crc), .in_tail(in_tail), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
  .dout_o(dout_o), .in_ready_o(in_ready_o), .fin_o(fin_o), .pass_o(pass_o),
  .err_o(err_o), .abort_o(abort_o)
);

// File: tb/test_sercfg_loader.sv
`timescale 1ns/1ps
module test_sercfg_loader;

  localparam int H    = 2;
  localparam int TO   = 60;
  localparam int HOLD = 4;
  localparam int CW   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] nbytes = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, prog_n, cclk, dout, abort_p, fin, pass_f;
  logic [1:0] err;
  logic init_n = 1'b1, done = 1'b0;

  always #2.5 clk = ~clk;

  sercfg_loader #(.HALF_CYC(H), .TIMEOUT_CYC(TO), .HOLD_CYC(HOLD), .CNT_W(CW)) i_sercfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nbytes_i(nbytes),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .prog_n_o(prog_n), .cclk_o(cclk), .dout_o(dout), .init_n_i(init_n),
    .done_i(done), .abort_o(abort_p), .fin_o(fin), .pass_o(pass_f), .err_o(err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- device stand-in ----------------
  int d_lo = 2, d_hi = 3, crc_rise = 0, done_rise = 0, dev_nb = 0;
  int lo_cnt = 0, hi_cnt = 0, rises = 0;
  bit cfg_seen = 0, crc_fired = 0, prev_cclk = 0;
  bit cap[$];

  always @(posedge clk) begin
    if (rst_n) begin
      if (!prog_n) begin
        lo_cnt++; hi_cnt = 0; cfg_seen = 1; rises = 0; crc_fired = 0;
        done <= 1'b0;
        if (d_lo >= 0 && lo_cnt > d_lo) init_n <= 1'b0;
        else if (d_lo < 0) init_n <= 1'b1;
      end else begin
        lo_cnt = 0;
        if (cfg_seen) begin
          hi_cnt++;
          if (d_hi >= 0 && hi_cnt > d_hi && !crc_fired) init_n <= 1'b1;
        end
      end
      if (cclk && !prev_cclk) begin
        rises++;
        if (rises <= 8 * dev_nb) cap.push_back(dout);
        if (crc_rise > 0 && rises == crc_rise) begin init_n <= 1'b0; crc_fired = 1; end
        if (done_rise > 0 && rises >= done_rise) done <= 1'b1;
      end
      prev_cclk = cclk;
    end
  end

  // ---------------- stream feeder ----------------
  logic [7:0] feed_q[$];
  int gap = 0, gap_len = 0, taken = 0;

  always @(posedge clk) begin
    bit took;
    took = in_valid && in_ready;
    #1;
    if (took) begin void'(feed_q.pop_front()); taken++; gap = gap_len; end
    else if (gap > 0) gap--;
    in_valid = (feed_q.size() > 0) && (gap == 0);
    in_data  = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
  end

  // ---------------- reference model ----------------
  int m_ph = 0, m_wait = 0, m_half = 0, m_bitn = 0, m_left = 0;
  logic [7:0] m_sr = 0;
  bit e_prog_n = 1, e_cclk = 0, e_dout = 0, e_fin = 0, e_abort = 0, e_pass = 0;
  int e_err = 0;

  always @(posedge clk) begin
    int code;
    cyc++;
    if (!rst_n) begin
      m_ph = 0; e_prog_n = 1; e_cclk = 0; e_dout = 0; e_fin = 0; e_abort = 0; e_pass = 0; e_err = 0;
    end else begin
      code = -1; e_fin = 0; e_abort = 0;
      case (m_ph)
        0: if (start) begin m_ph = 1; m_wait = 0; e_prog_n = 0; m_left = nbytes; e_pass = 0; e_err = 0; end
        1: if (!init_n) begin m_ph = 2; m_wait = 0; end
           else if (m_wait == TO - 1) code = 2; else m_wait++;
        2: if (m_wait == HOLD - 1) begin e_prog_n = 1; m_ph = 3; m_wait = 0; end else m_wait++;
        3: if (init_n) begin m_ph = 4; m_wait = 0; end
           else if (m_wait == TO - 1) code = 2; else m_wait++;
        4: if (m_left == 0) begin m_ph = 6; e_dout = 1; m_wait = 0; m_half = 0; end
           else if (!done && !init_n) code = 1;
           else if (in_valid) begin
             m_sr = in_data; m_left--; e_cclk = 0; m_bitn = 0; e_dout = m_sr[7]; m_half = 0; m_ph = 5;
           end
        5: begin
             m_half++;
             if (m_half == H) begin
               m_half = 0;
               if (!e_cclk) e_cclk = 1;
               else if (m_bitn == 7) m_ph = 4;
               else begin m_bitn++; e_cclk = 0; e_dout = m_sr[7 - m_bitn]; end
             end
           end
        6: if (done) code = 0;
           else if (m_wait == TO - 1) code = 3;
           else begin
             m_wait++; m_half++;
             if (m_half == H) begin m_half = 0; e_cclk = !e_cclk; end
           end
        default: ;
      endcase
      if (code >= 0) begin
        m_ph = 0; e_fin = 1; e_pass = (code == 0); e_err = code;
        e_prog_n = 1; e_cclk = 0; e_dout = 0; e_abort = (code == 1 || code == 2);
      end
    end
  end

  int fin_seen = 0, abort_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ready;
      e_ready = (m_ph == 4) && (m_left != 0) && !(!done && !init_n);
      chk("R1/R2 prog_n", prog_n, e_prog_n);
      chk("R3/R6 cclk", cclk, e_cclk);
      chk("R3/R6 dout", dout, e_dout);
      chk("R5 in_ready", in_ready, e_ready);
      chk("R7 fin", fin, e_fin);
      chk("R7 pass", pass_f, e_pass);
      chk("R7 err", err, e_err);
      chk("R8 abort", abort_p, e_abort);
      if (fin) fin_seen++;
      if (abort_p) abort_seen++;
    end
  end

  always @(posedge clk) if (cyc > 190000) begin
    n_bad++; $display("FAIL watchdog expired"); summary();
  end

  // ---------------- tests ----------------
  task automatic run(input int nb, input logic [7:0] bytes[$], input int lo, input int hi,
                     input int crc, input int dn, input int gl, input bit poke_start);
    int lim;
    d_lo = lo; d_hi = hi; crc_rise = crc; done_rise = dn; dev_nb = nb; gap_len = gl;
    cap.delete(); taken = 0; fin_seen = 0; abort_seen = 0;
    foreach (bytes[k]) feed_q.push_back(bytes[k]);
    @(posedge clk); #1; nbytes = CW'(nb); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    lim = 0;
    while (fin_seen == 0 && lim < 5000) begin
      @(negedge clk); lim++;
      if (poke_start && lim == 40) begin #1; start = 1'b1; @(posedge clk); #1; start = 1'b0; end
    end
    if (lim >= 5000) begin n_bad++; $display("FAIL run timed out waiting for fin (R7)"); end
    repeat (3) @(negedge clk);
    feed_q.delete();
  endtask

  initial begin
    logic [7:0] b[$];
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset prog_n", prog_n, 1); chk("R9 reset cclk", cclk, 0);
    chk("R7 reset fin", fin, 0); chk("R5 reset ready", in_ready, 0);

    // Normal load, gaps in the stream, a stray start mid-load
    b = '{8'hA5, 8'h3C, 8'h01};
    run(3, b, 3, 5, 0, 27, 5, 1);
    chk("R7 normal pass", pass_f, 1); chk("R7 normal code", err, 0);
    chk("R1 stray start ignored: single fin", fin_seen, 1);
    chk("R3 bit count", cap.size(), 24);
    for (int i = 0; i < 24 && i < cap.size(); i++)
      chk("R3 serial bit MSB first", cap[i], b[i / 8][7 - (i % 8)]);
    chk("R8 no abort on pass", abort_seen, 0);

    // Zero-byte load goes straight to trailing clocks
    b = {};
    run(0, b, 1, 2, 0, 2, 0, 0);
    chk("R6 zero-byte pass", pass_f, 1); chk("R5 zero-byte no take", taken, 0);

    // INIT never falls
    b = '{8'h55};
    run(1, b, -1, 2, 0, 9, 0, 0);
    chk("R2 init-low timeout code", err, 2); chk("R8 abort on init-low timeout", abort_seen, 1);
    chk("R2 no data before init", taken, 0);

    // INIT never rises
    run(1, b, 1, -1, 0, 9, 0, 0);
    chk("R2 init-high timeout code", err, 2); chk("R8 abort on init-high timeout", abort_seen, 1);
    chk("R2 no data while init low", taken, 0);

    // Checksum fault after the second byte
    b = '{8'h81, 8'h7E, 8'hC3, 8'h18};
    run(4, b, 2, 2, 16, 40, 0, 0);
    chk("R4 crc code", err, 1); chk("R4 crc fail flag", pass_f, 0);
    chk("R4 bytes taken before fault", taken, 2); chk("R8 abort on crc", abort_seen, 1);

    // DONE never rises
    b = '{8'hF0};
    run(1, b, 2, 2, 0, 0, 0, 0);
    chk("R9 done timeout code", err, 3); chk("R8 no abort on done timeout", abort_seen, 0);
    chk("R9 clock parked low", cclk, 0); chk("R9 program released", prog_n, 1);

    // Back-to-back bytes with no stream gaps
    b = '{8'h00, 8'hFF};
    run(2, b, 1, 1, 0, 16, 0, 0);
    chk("R5 back-to-back pass", pass_f, 1);
    for (int i = 0; i < 16 && i < cap.size(); i++)
      chk("R3 serial bit back-to-back", cap[i], b[i / 8][7 - (i % 8)]);

    summary();
  end

endmodule